// File: doc/BRIEF.md
# Low-Voltage Reset Filter

This block is the digital back end of a supply supervisor. An analog comparator raises a flag whenever the supply sits below its 4.0 V trip point. The block turns that raw flag into a clean active-low reset for the rest of the chip. It first passes the flag through a two-flop synchroniser. It then ignores any low-supply episode shorter than a minimum duration, which corresponds to 1 µs in the target setting. Once an episode qualifies, it holds reset for as long as the flag stays set. After the flag clears, it keeps reset asserted for a fixed recovery time, 10 ms in the target setting, before releasing it.

Both durations are parameters counted in cycles of a free-running reference clock. A qualified dip during the recovery time restarts that time from zero. The digital power-on reset `por_n` starts the block as though the supply had just recovered, so reset is released only after one full recovery time. The block carries no data stream: all its pins are plain level signals, with no valid/ready handshake and no back-pressure.

Top module: `lvr_filter`

## Requirements
- R1: The comparator flag `supply_low_i` (1 = supply below threshold) is sampled through two flops before filtering, so the filter sees the flag two clocks late.
- R2: If the flag is high for at least GLITCH_CYC consecutive clock edges, `rst_out_n` goes low at the (GLITCH_CYC+3)-th rising edge, counting the first edge that samples the flag high as edge 1.
- R3: A flag pulse covering at most GLITCH_CYC-1 edges never drives `rst_out_n` low.
- R4: The filter needs consecutive samples. Two pulses of GLITCH_CYC-1 edges each, separated by one low edge, do not add up and cause no reset.
- R5: Once reset is asserted, `rst_out_n` stays low for the whole time the flag stays high, however long that is.
- R6: After a qualified episode, `rst_out_n` returns high at edge L+HOLD_CYC+3, where L is the number of edges the flag was high and edges are counted as in R2.
- R7: A qualified dip during the recovery time restarts the recovery count from the end of that dip. A sub-threshold dip during the recovery time does not move the release edge.
- R8: While `por_n` is low, `rst_out_n` is low. When `por_n` goes high with the flag low, `rst_out_n` goes high at the HOLD_CYC-th rising edge after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Asynchronous active-low power-on reset of the filter logic |
| supply_low_i | input | 1 | Raw comparator flag, 1 = supply below threshold |
| rst_out_n | output | 1 | Filtered active-low system reset |

## Verification
The bench drives the flag with pulses of exactly the qualifying length, one edge shorter, and much longer. These patterns separate a correct threshold from an off-by-one and show that reset stays held during a long low. Two short pulses split by a single low edge test whether the filter counts consecutive samples or a running total. Second dips of qualifying and sub-qualifying length inside the recovery window show whether the hold counter restarts only when it should. The power-up case checks that the hold runs from `por_n` release rather than from the first dip.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  // width needed to hold the values 0..n
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lvr_glitch_filter.sv
module lvr_glitch_filter
  import lvr_pkg::*;
#(
  parameter int GLITCH_CYC = 50
) (
  input  logic clk,
  input  logic por_n,
  input  logic low_i,
  output logic qual_o
);
  localparam int GW = cnt_w(GLITCH_CYC);
  localparam logic [GW-1:0] LIMIT = GW'(GLITCH_CYC);

  logic [GW-1:0] run_q;

  // count consecutive low-supply samples, saturate at the limit
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             run_q <= '0;
    else if (!low_i)        run_q <= '0;
    else if (run_q != LIMIT) run_q <= run_q + 1'b1;
  end

  assign qual_o = (run_q == LIMIT);
endmodule

// File: rtl/lvr_hold_timer.sv
module lvr_hold_timer
  import lvr_pkg::*;
#(
  parameter int HOLD_CYC = 500000
) (
  input  logic clk,
  input  logic por_n,
  input  logic qual_i,
  output logic rst_n_o
);
  localparam int HW = cnt_w(HOLD_CYC);
  localparam logic [HW-1:0] DONE = HW'(HOLD_CYC);

  logic [HW-1:0] elapsed_q;

  // restart while a qualified low is present, else run up to DONE
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 elapsed_q <= '0;
    else if (qual_i)            elapsed_q <= '0;
    else if (elapsed_q != DONE) elapsed_q <= elapsed_q + 1'b1;
  end

  assign rst_n_o = (elapsed_q == DONE);
endmodule

// File: rtl/lvr_filter.sv
module lvr_filter #(
  parameter int GLITCH_CYC = 50,
  parameter int HOLD_CYC   = 500000
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low_i,
  output logic rst_out_n
);
  logic low_sync;
  logic low_qual;

  // R1: two-flop synchroniser on the comparator flag
  lvr_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .por_n  (por_n),
    .async_i(supply_low_i),
    .sync_o (low_sync)
  );

  lvr_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk   (clk),
    .por_n (por_n),
    .low_i (low_sync),
    .qual_o(low_qual)
  );

  lvr_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .por_n  (por_n),
    .qual_i (low_qual),
    .rst_n_o(rst_out_n)
  );
endmodule

// File: rtl/lvr_filter_chk.sv
module lvr_filter_chk (
  input logic clk,
  input logic por_n,
  input logic supply_low_i,
  input logic low_sync,
  input logic low_qual,
  input logic rst_out_n
);
  // R1
  sync_delay_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(low_sync) |-> $past(supply_low_i, 2));

  // R3
  glitch_qual_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(low_qual) |-> $past(low_sync));

  // R5
  low_held_chk: assert property (@(posedge clk) disable iff (!por_n)
    low_qual |=> !rst_out_n);

  // R6
  release_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> !$past(low_qual));

  // R8
  always @(posedge clk) begin
    if (!por_n) por_hold_chk: assert (!rst_out_n);
  end
endmodule

bind lvr_filter lvr_filter_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .supply_low_i(supply_low_i),
  .low_sync    (low_sync),
  .low_qual    (low_qual),
  .rst_out_n   (rst_out_n)
);

// File: tb/tb_lvr_filter.sv
module tb_lvr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int G = 4;
  localparam int H = 20;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_low_i = 1'b0;
  logic rst_out_n;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvr_filter #(.GLITCH_CYC(G), .HOLD_CYC(H)) dut (
    .clk(clk), .por_n(por_n), .supply_low_i(supply_low_i), .rst_out_n(rst_out_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flag high for hi1 edges, low lo edges, high hi2 edges, then low.
  // asrt = first edge with reset low, rel = first high edge after that (-1 if none)
  task automatic run_pattern(input int hi1, input int lo, input int hi2,
                             output int asrt, output int rel);
    int tot = hi1 + lo + hi2 + H + 12;
    asrt = -1; rel = -1;
    @(negedge clk);
    supply_low_i = (hi1 > 0);
    for (int n = 1; n <= tot; n++) begin
      @(posedge clk); #1;
      if (!rst_out_n && asrt < 0) asrt = n;
      if (rst_out_n && asrt >= 0 && rel < 0) rel = n;
      @(negedge clk);
      supply_low_i = (n < hi1) || (n >= hi1 + lo && n < hi1 + lo + hi2);
    end
    supply_low_i = 1'b0;
  endtask

  task automatic t_power_up;
    int n = 0;
    repeat (3) @(negedge clk);
    check(rst_out_n == 1'b0, "R8 reset state", int'(rst_out_n), 0);
    por_n = 1'b1;
    while (n < 100) begin
      @(posedge clk); n++; #1;
      if (rst_out_n) break;
    end
    check(n == H, "R8 power-up release edge", n, H);
  endtask

  task automatic t_exact;
    int a, r;
    run_pattern(G, 0, 0, a, r);
    check(a == G + 3, "R1 R2 assert edge exact pulse", a, G + 3);
    check(r == G + H + 3, "R6 release edge exact pulse", r, G + H + 3);
  endtask

  task automatic t_long;
    int a, r;
    run_pattern(3*G, 0, 0, a, r);
    check(a == G + 3, "R2 assert edge long low", a, G + 3);
    check(r == 3*G + H + 3, "R5 held through long low", r, 3*G + H + 3);
  endtask

  task automatic t_short;
    int a, r;
    run_pattern(G - 1, 0, 0, a, r);
    check(a == -1, "R3 short pulse ignored", a, -1);
  endtask

  task automatic t_split;
    int a, r;
    run_pattern(G - 1, 1, G - 1, a, r);
    check(a == -1, "R4 split pulses ignored", a, -1);
  endtask

  task automatic t_redip;
    int a, r;
    run_pattern(G, 6, G, a, r);
    check(a == G + 3, "R7 assert before re-dip", a, G + 3);
    check(r == 2*G + 6 + H + 3, "R7 qualified re-dip restarts hold", r, 2*G + 6 + H + 3);
  endtask

  task automatic t_short_redip;
    int a, r;
    run_pattern(G, 6, G - 1, a, r);
    check(a == G + 3, "R7 assert before short re-dip", a, G + 3);
    check(r == G + H + 3, "R7 short re-dip keeps release", r, G + H + 3);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_power_up();
    t_exact();
    t_long();
    t_short();
    t_split();
    t_redip();
    t_short_redip();
    check(rst_out_n == 1'b1, "R6 idle after tests", int'(rst_out_n), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule